// File: doc/BRIEF.md
# Fallback-Clock Reset Sequencer

This block times the internal reset that follows power-on and decides which clock the chip runs from once that reset ends. A counter measures the reset period. It starts on a backup oscillator that is always available. If the clock monitor reports a working external clock while reset is still active, the block switches the counter to that clock and later releases reset normally. If no external clock has appeared by the end of the period, reset is still released, but the chip stays on the backup clock in a degraded "fallback" mode. A status flag and a latched interrupt flag mark this mode.

While in fallback mode the block samples the clock monitor at fixed points on the counter. The first sample is half a counter period after reset release, and later samples come one full period apart. When a sample finds the external clock, the block moves to that clock and raises the latched flag again. If the PLL supply is off, fallback mode cannot be used. In that case every count comes from the external clock, and the sequence waits for as long as that clock is absent.

The sequencer runs on a fast free-running clock `clk`. Each cycle of the backup or external clock arrives as a one-cycle tick. The glitch-free clock multiplexer acts on `selExt`.

Top module: `fallback_reset_seq`

## Requirements
- R1: While `porPulse` is high, and at any time it is raised, the outputs return to their initial values: `intReset`=1, `limpFlag`=0, `limpIrqFlag`=0, `irqReq`=0 and the count is cleared. `selExt`=0 when `pllSupplyOn`=1.
- R2: After `porPulse` falls, `intReset` stays 1 for exactly 2^(CNT_WIDTH-1) ticks of the selected clock. It drops in the cycle after the last of those ticks and never rises again without a new `porPulse`.
- R3: If `extPresent`=1 in any cycle of the reset period, `selExt` is 1 from the next cycle on. Counting continues, without restarting, on `tickExt` only, and `selExt` stays 1.
- R4: If reset ends with `selExt`=1, `limpFlag` and `limpIrqFlag` stay 0.
- R5: If reset ends with no external clock seen, `limpFlag` and `limpIrqFlag` become 1 in the same cycle that `intReset` drops, and `selExt` stays 0 while `limpFlag` is 1.
- R6: In fallback mode `extPresent` is sampled at backup ticks only. The first sample is at tick 2^(CNT_WIDTH-1) after release. Each later sample comes 2^CNT_WIDTH ticks after the one before it.
- R7: A sample that finds `extPresent`=1 clears `limpFlag`, sets `selExt` and sets `limpIrqFlag`, all in the cycle after that tick.
- R8: Between sample points `extPresent` has no effect in fallback mode.
- R9: With `pllSupplyOn`=0, `selExt` is 1, `tickBackup` is ignored, reset advances only on `tickExt`, and `limpFlag` is never set.
- R10: `limpIrqFlag` holds until a cycle with `flagClear`=1. A set in the same cycle wins over the clear.
- R11: `irqReq` equals `limpIrqFlag` AND `irqEnable`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast free-running sequencer clock |
| porPulse | input | 1 | Power-on reset, active high, asynchronous |
| tickBackup | input | 1 | One-cycle pulse per backup oscillator cycle |
| tickExt | input | 1 | One-cycle pulse per external clock cycle |
| extPresent | input | 1 | Clock monitor: external clock is present |
| pllSupplyOn | input | 1 | PLL supply enabled; 0 disables fallback mode |
| irqEnable | input | 1 | Interrupt enable for the latched flag |
| flagClear | input | 1 | Clears the latched interrupt flag |
| selExt | output | 1 | Clock select: 1 = external, 0 = backup |
| intReset | output | 1 | Internal reset, active high |
| limpFlag | output | 1 | Fallback mode status |
| limpIrqFlag | output | 1 | Latched interrupt flag for fallback entry or exit |
| irqReq | output | 1 | Interrupt request |

## Verification
The bench builds the sequencer with CNT_WIDTH=6. This gives a 32-tick reset period and sample points at 32 ticks and then every 64 ticks. Both reset-exit paths, a failed first sample followed by a successful second one, and a switch to the external clock partway through reset therefore fit in a few hundred cycles. Thirty random power-on rounds then mix PLL supply states, clock-monitor onset times and glitches, and flag clears.

// File: rtl/fallback_reset_pkg.sv
package fallback_reset_pkg;

  typedef enum logic [1:0] {
    PH_RESET = 2'd0,
    PH_LIMP  = 2'd1,
    PH_EXT   = 2'd2
  } phase_t;

  typedef struct packed {
    logic inc;
    logic clr;
  } cntCmd_t;

endpackage

// File: rtl/fallback_reset_cnt.sv
module fallback_reset_cnt
  import fallback_reset_pkg::*;
#(
  parameter int CNT_WIDTH = 13
) (
  input  logic    clk,
  input  logic    porPulse,
  input  cntCmd_t cmd,
  input  logic    useExt,
  input  logic    tickBackup,
  input  logic    tickExt,
  output logic    tick,
  output logic    hitHalf,
  output logic    hitFull
);

  localparam int HALF = 1 << (CNT_WIDTH - 1);
  localparam logic [CNT_WIDTH-1:0] HALF_LAST = CNT_WIDTH'(HALF - 1);

  logic [CNT_WIDTH-1:0] cntQ;

  // Tick of whichever clock currently drives the counter
  assign tick = useExt ? tickExt : tickBackup;

  always_ff @(posedge clk or posedge porPulse) begin
    if (porPulse) begin
      cntQ <= '0;
    end else if (cmd.clr) begin
      cntQ <= '0;
    end else if (cmd.inc) begin
      cntQ <= cntQ + 1'b1;
    end
  end

  assign hitHalf = (cntQ == HALF_LAST);
  assign hitFull = &cntQ;

endmodule

// File: rtl/fallback_reset_ctrl.sv
module fallback_reset_ctrl
  import fallback_reset_pkg::*;
(
  input  logic    clk,
  input  logic    porPulse,
  input  logic    tick,
  input  logic    hitHalf,
  input  logic    hitFull,
  input  logic    extPresent,
  input  logic    pllSupplyOn,
  output cntCmd_t cmd,
  output logic    selExt,
  output logic    intReset,
  output logic    limpFlag,
  output logic    setIrqFlag
);

  phase_t phaseQ, phaseD;
  logic   extSelQ, extSelD;
  logic   firstDoneQ, firstDoneD;
  logic   limpQ, limpD;
  logic   checkPoint;

  always_ff @(posedge clk or posedge porPulse) begin
    if (porPulse) begin
      phaseQ     <= PH_RESET;
      extSelQ    <= 1'b0;
      firstDoneQ <= 1'b0;
      limpQ      <= 1'b0;
    end else begin
      phaseQ     <= phaseD;
      extSelQ    <= extSelD;
      firstDoneQ <= firstDoneD;
      limpQ      <= limpD;
    end
  end

  // Sample point: half period first, full period afterwards
  assign checkPoint = firstDoneQ ? hitFull : hitHalf;

  always_comb begin
    phaseD     = phaseQ;
    extSelD    = extSelQ;
    firstDoneD = firstDoneQ;
    limpD      = limpQ;
    cmd        = '0;
    setIrqFlag = 1'b0;
    unique case (phaseQ)
      PH_RESET: begin
        if (pllSupplyOn && extPresent) extSelD = 1'b1;
        if (tick) begin
          if (hitHalf) begin
            cmd.clr = 1'b1;
            if (extSelQ || extPresent || !pllSupplyOn) begin
              phaseD  = PH_EXT;
              extSelD = 1'b1;
            end else begin
              phaseD     = PH_LIMP;
              limpD      = 1'b1;
              firstDoneD = 1'b0;
              setIrqFlag = 1'b1;
            end
          end else begin
            cmd.inc = 1'b1;
          end
        end
      end
      PH_LIMP: begin
        if (tick) begin
          if (checkPoint) begin
            cmd.clr    = 1'b1;
            firstDoneD = 1'b1;
            if (extPresent) begin
              phaseD     = PH_EXT;
              extSelD    = 1'b1;
              limpD      = 1'b0;
              setIrqFlag = 1'b1;
            end
          end else begin
            cmd.inc = 1'b1;
          end
        end
      end
      PH_EXT: begin
        cmd.clr = 1'b1;
      end
      default: begin
        phaseD = PH_RESET;
      end
    endcase
  end

  assign selExt   = extSelQ | ~pllSupplyOn;
  assign intReset = (phaseQ == PH_RESET);
  assign limpFlag = limpQ;

endmodule

// File: rtl/fallback_reset_flag.sv
module fallback_reset_flag (
  input  logic clk,
  input  logic porPulse,
  input  logic setFlag,
  input  logic flagClear,
  input  logic irqEnable,
  output logic flagOut,
  output logic irqOut
);

  logic flagQ;

  // Set has priority over a clear in the same cycle
  always_ff @(posedge clk or posedge porPulse) begin
    if (porPulse) begin
      flagQ <= 1'b0;
    end else if (setFlag) begin
      flagQ <= 1'b1;
    end else if (flagClear) begin
      flagQ <= 1'b0;
    end
  end

  assign flagOut = flagQ;
  assign irqOut  = flagQ & irqEnable;

endmodule

// File: rtl/fallback_reset_seq.sv
module fallback_reset_seq
  import fallback_reset_pkg::*;
#(
  parameter int CNT_WIDTH = 13
) (
  input  logic clk,
  input  logic porPulse,
  input  logic tickBackup,
  input  logic tickExt,
  input  logic extPresent,
  input  logic pllSupplyOn,
  input  logic irqEnable,
  input  logic flagClear,
  output logic selExt,
  output logic intReset,
  output logic limpFlag,
  output logic limpIrqFlag,
  output logic irqReq
);

  cntCmd_t cntCmd;
  logic    tickSel;
  logic    hitHalf;
  logic    hitFull;
  logic    setIrqFlag;

  fallback_reset_cnt #(
    .CNT_WIDTH(CNT_WIDTH)
  ) u_cnt (
    .clk       (clk),
    .porPulse  (porPulse),
    .cmd       (cntCmd),
    .useExt    (selExt),
    .tickBackup(tickBackup),
    .tickExt   (tickExt),
    .tick      (tickSel),
    .hitHalf   (hitHalf),
    .hitFull   (hitFull)
  );

  fallback_reset_ctrl u_ctrl (
    .clk        (clk),
    .porPulse   (porPulse),
    .tick       (tickSel),
    .hitHalf    (hitHalf),
    .hitFull    (hitFull),
    .extPresent (extPresent),
    .pllSupplyOn(pllSupplyOn),
    .cmd        (cntCmd),
    .selExt     (selExt),
    .intReset   (intReset),
    .limpFlag   (limpFlag),
    .setIrqFlag (setIrqFlag)
  );

  fallback_reset_flag u_flag (
    .clk      (clk),
    .porPulse (porPulse),
    .setFlag  (setIrqFlag),
    .flagClear(flagClear),
    .irqEnable(irqEnable),
    .flagOut  (limpIrqFlag),
    .irqOut   (irqReq)
  );

endmodule

// File: rtl/fallback_reset_seq_chk.sv
module fallback_reset_seq_chk (
  input logic clk,
  input logic porPulse,
  input logic pllSupplyOn,
  input logic flagClear,
  input logic selExt,
  input logic intReset,
  input logic limpFlag,
  input logic limpIrqFlag
);

  AST_RESET_NO_REENTRY: assert property (@(posedge clk) disable iff (porPulse)
    !$rose(intReset)); // R2

  AST_EXT_SEL_STICKY: assert property (@(posedge clk) disable iff (porPulse)
    (selExt && pllSupplyOn) |=> selExt); // R3

  AST_LIMP_ENTRY_FLAGS: assert property (@(posedge clk) disable iff (porPulse)
    $rose(limpFlag) |-> (limpIrqFlag && !intReset)); // R5

  AST_LIMP_ON_BACKUP: assert property (@(posedge clk) disable iff (porPulse)
    limpFlag |-> !selExt); // R5

  AST_LIMP_EXIT_FLAG: assert property (@(posedge clk) disable iff (porPulse)
    $fell(limpFlag) |-> (limpIrqFlag && selExt)); // R7

  AST_NO_LIMP_WITHOUT_PLL: assert property (@(posedge clk) disable iff (porPulse)
    !pllSupplyOn |-> !limpFlag); // R9

  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (porPulse)
    (limpIrqFlag && !flagClear) |=> limpIrqFlag); // R10

endmodule

bind fallback_reset_seq fallback_reset_seq_chk u_chk (.*);

// File: tb/fallback_reset_seq_bench.sv
`timescale 1ns/100ps
module fallback_reset_seq_bench;

  localparam int W    = 6;
  localparam int HALF = 1 << (W - 1);
  localparam int FULL = 1 << W;

  logic clk = 1'b0;
  logic porPulse = 1'b1;
  logic tickBackup = 1'b0, tickExt = 1'b0, extPresent = 1'b0;
  logic pllSupplyOn = 1'b1, irqEnable = 1'b0, flagClear = 1'b0;
  logic selExt, intReset, limpFlag, limpIrqFlag, irqReq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  fallback_reset_seq #(.CNT_WIDTH(W)) u_fallback_reset_seq (
    .clk(clk), .porPulse(porPulse), .tickBackup(tickBackup), .tickExt(tickExt),
    .extPresent(extPresent), .pllSupplyOn(pllSupplyOn), .irqEnable(irqEnable),
    .flagClear(flagClear), .selExt(selExt), .intReset(intReset),
    .limpFlag(limpFlag), .limpIrqFlag(limpIrqFlag), .irqReq(irqReq)
  );

  // Reference model, built from the requirements
  int mPhase = 0;  // 0 reset, 1 fallback, 2 external
  int mCnt = 0;
  bit mExt = 0, mFirst = 0, mLimp = 0, mFlag = 0;

  always @(posedge clk) begin
    bit selNow, tk, setF;
    if (porPulse) begin
      mPhase = 0; mCnt = 0; mExt = 0; mFirst = 0; mLimp = 0; mFlag = 0;
    end else begin
      selNow = mExt || !pllSupplyOn;
      tk = selNow ? tickExt : tickBackup;
      setF = 0;
      if (mPhase == 0) begin
        if (tk) begin
          if (mCnt == HALF - 1) begin
            mCnt = 0;
            if (mExt || extPresent || !pllSupplyOn) begin
              mPhase = 2; mExt = 1;
            end else begin
              mPhase = 1; mLimp = 1; setF = 1; mFirst = 0;
            end
          end else mCnt++;
        end
        if (pllSupplyOn && extPresent) mExt = 1;
      end else if (mPhase == 1) begin
        if (tk) begin
          if (mCnt == (mFirst ? FULL - 1 : HALF - 1)) begin
            mCnt = 0; mFirst = 1;
            if (extPresent) begin
              mPhase = 2; mExt = 1; mLimp = 0; setF = 1;
            end
          end else mCnt++;
        end
      end
      if (setF) mFlag = 1;
      else if (flagClear) mFlag = 0;
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(posedge clk) begin
    #1;
    if (!done) begin
      chk("R2",  intReset,    (mPhase == 0), "intReset");
      chk("R3",  selExt,      (mExt || !pllSupplyOn), "selExt");
      chk("R5",  limpFlag,    mLimp, "limpFlag");
      chk("R10", limpIrqFlag, mFlag, "limpIrqFlag");
      chk("R11", irqReq,      (mFlag && irqEnable), "irqReq");
    end
  end

  task automatic cyc(input logic bk, input logic ex, input logic pres, input logic clr);
    @(negedge clk);
    tickBackup = bk; tickExt = ex; extPresent = pres; flagClear = clr;
    @(posedge clk); #1.5;
  endtask

  task automatic por(input logic pll);
    @(negedge clk);
    porPulse = 1'b1; pllSupplyOn = pll;
    tickBackup = 0; tickExt = 0; extPresent = 0; flagClear = 0;
    @(negedge clk); @(negedge clk);
    porPulse = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int seedVal;
    seedVal = $urandom(32'd4242);
    // R1: initial state while power-on reset is high
    @(posedge clk); #1.5;
    chk("R1", intReset, 1'b1, "intReset in POR");
    chk("R1", selExt, 1'b0, "selExt in POR");
    chk("R1", limpFlag | limpIrqFlag | irqReq, 1'b0, "flags in POR");

    // R2/R5: no external clock, reset lasts HALF backup ticks
    por(1'b1);
    for (int i = 0; i < HALF - 1; i++) cyc(1, 0, 0, 0);
    chk("R2", intReset, 1'b1, "reset one tick before end");
    cyc(1, 0, 0, 0);
    chk("R2", intReset, 1'b0, "reset released");
    chk("R5", limpFlag, 1'b1, "fallback entered");
    chk("R5", limpIrqFlag, 1'b1, "flag on entry");
    chk("R5", selExt, 1'b0, "backup kept");

    // R8: glitch between sample points ignored
    cyc(0, 0, 1, 0);
    cyc(1, 0, 1, 0);
    cyc(0, 0, 0, 0);
    chk("R8", limpFlag, 1'b1, "glitch ignored");
    chk("R8", selExt, 1'b0, "glitch ignored sel");
    // R10: clear flag
    cyc(0, 0, 0, 1);
    chk("R10", limpIrqFlag, 1'b0, "flag cleared");
    // R6: first sample (tick 32 after release) sees no clock; 1 tick already spent
    for (int i = 0; i < HALF - 1; i++) cyc(1, 0, 0, 0);
    chk("R6", limpFlag, 1'b1, "first sample failed");
    // R6: second sample FULL ticks later, clock present
    for (int i = 0; i < FULL - 1; i++) cyc(1, 0, 1, 0);
    chk("R6", limpFlag, 1'b1, "before second sample");
    irqEnable = 1'b1;
    cyc(1, 0, 1, 1);
    chk("R7", limpFlag, 1'b0, "fallback exited");
    chk("R7", selExt, 1'b1, "external selected");
    chk("R10", limpIrqFlag, 1'b1, "set wins over clear");
    chk("R11", irqReq, 1'b1, "irq with enable");
    @(negedge clk); irqEnable = 1'b0;
    @(posedge clk); #1.5;
    chk("R11", irqReq, 1'b0, "irq masked");

    // R1: power-on reset mid-operation
    por(1'b1);
    cyc(0, 0, 0, 0);
    chk("R1", intReset, 1'b1, "reset reasserted");
    chk("R1", limpIrqFlag | selExt, 1'b0, "state cleared");

    // R3/R4: external clock seen after 10 backup ticks
    for (int i = 0; i < 10; i++) cyc(1, 0, 0, 0);
    cyc(0, 0, 1, 0);
    chk("R3", selExt, 1'b1, "switch to external");
    for (int i = 0; i < 30; i++) cyc(1, 0, 0, 0);
    chk("R3", intReset, 1'b1, "backup ticks ignored");
    for (int i = 0; i < HALF - 11; i++) cyc(0, 1, 0, 0);
    chk("R3", intReset, 1'b1, "count continues");
    cyc(0, 1, 0, 0);
    chk("R4", intReset, 1'b0, "released on external");
    chk("R4", limpFlag | limpIrqFlag, 1'b0, "no fallback flags");

    // R9: PLL supply off
    por(1'b0);
    cyc(0, 0, 0, 0);
    chk("R9", selExt, 1'b1, "external forced");
    for (int i = 0; i < 100; i++) cyc(1, 0, 0, 0);
    chk("R9", intReset, 1'b1, "stalls without external");
    for (int i = 0; i < HALF; i++) cyc(0, 1, 0, 0);
    chk("R9", intReset, 1'b0, "released on external");
    chk("R9", limpFlag, 1'b0, "no fallback");

    // Random rounds
    for (int r = 0; r < 30; r++) begin
      int onAt;
      por(($urandom % 5) != 0);
      onAt = ($urandom % 3 == 0) ? 1000 : int'($urandom % 300);
      irqEnable = $urandom % 2;
      for (int i = 0; i < 300; i++) begin
        cyc($urandom % 2, ($urandom % 3) == 0,
            (i >= onAt) || (($urandom % 40) == 0), ($urandom % 25) == 0);
        if ($urandom % 50 == 0) irqEnable = ~irqEnable;
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule